// File: doc/BRIEF.md
# Packet-Ready Tracker for a Multi-Queue FIFO

This block sits beside the storage of a multi-queue FIFO and adds framed transfers to it. Each written word may carry a start marker and an end marker. Each read word leaves storage with its own end marker. For every queue the tracker keeps a count of complete packets held in storage. When packet operation is chosen, a queue's status line reports "at least one whole packet stored" in place of the usual almost-empty indication.

The operating mode is taken from a strap input while master reset is held, and it stays fixed until the next reset. In word mode the status lines pass the FIFO's almost-empty flags through unchanged, and the tracker neither counts nor flags anything. In packet mode the tracker watches the framing of each queue's writes. A packet that is too short, a start marker inside an open packet, or an end marker with no open packet sets a sticky error bit for that queue. The malformed packet is still counted, because its words are still stored. For the queue currently selected on the read side, a combined indication tells the consumer that a whole packet is ready and that the output word is valid.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While `rst_n` is low on a clock edge, `pkt_mode` takes the value of `mode_strap`. After reset it holds that value whatever the strap does.
- R2: With `pkt_mode` low, `q_flag` equals `ae_in` in every cycle and `pkt_err` stays all zero, whatever the write and read traffic.
- R3: In packet mode, a write with `wr_eop` high adds one to the complete-packet count of queue `wr_q`. Bit `wr_q` of `q_flag` is high from the cycle after that edge for as long as the count is nonzero.
- R4: In packet mode, a read with `rd_en` and `rd_eop` high subtracts one from the count of queue `rd_q`. The ready bit falls in the cycle after the count reaches zero. A read end marker on a queue whose count is zero has no effect.
- R5: A write end marker and a read end marker for the same queue on the same edge leave that queue's count unchanged.
- R6: The count saturates at 2^CNT_W-1. Further write end markers are dropped, so exactly 2^CNT_W-1 read end markers then return the ready bit to low.
- R7: A packet counts its words from the start word up to and including the end word. If it ends with fewer than MIN_LEN words, including a single word that carries both markers, bit `wr_q` of `pkt_err` is set. A packet of exactly MIN_LEN words sets no error.
- R8: A start marker written while that queue's packet is still open, or an end marker written while no packet is open, sets bit `wr_q` of `pkt_err`.
- R9: Error bits only ever rise after reset. They are cleared only by reset.
- R10: `rd_pkt_valid` is high exactly when `pkt_mode` is high, `rd_ov` is high, and queue `rd_q` has a nonzero count.
- R11: Traffic on one queue never changes another queue's count, ready bit or error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, synchronous; the strap is sampled while it is low |
| mode_strap | input | 1 | 1 selects packet mode, 0 selects word mode |
| wr_en | input | 1 | A word is written this cycle |
| wr_q | input | QW | Queue being written |
| wr_sop | input | 1 | Written word is a packet start |
| wr_eop | input | 1 | Written word is a packet end |
| rd_en | input | 1 | A word is read this cycle |
| rd_q | input | QW | Queue selected on the read side |
| rd_eop | input | 1 | Word read is a packet end |
| rd_ov | input | 1 | The FIFO output register holds a valid word |
| ae_in | input | NQ | Almost-empty flags from the FIFO, one per queue |
| pkt_mode | output | 1 | Latched operating mode |
| q_flag | output | NQ | Per-queue status: packet-ready in packet mode, `ae_in` in word mode |
| pkt_err | output | NQ | Sticky per-queue framing error |
| rd_pkt_valid | output | 1 | The selected queue holds a whole packet and the output word is valid |

## Verification
The bench builds the block with NQ=16, MIN_LEN=4 and CNT_W=3. The 3-bit count ceiling of seven puts count saturation within a few dozen cycles, so the bench can push past it and then drain it word by word. With sixteen queues, separate queues can carry a good packet, a short packet, bad framing and the simultaneous write/read case side by side. This lets the bench confirm that each queue's ready and error bits stay apart from the others. Two resets, one with each strap level, cover the change from packet mode to word mode and the clearing of the sticky error bits.

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker #(
  parameter int NQ      = 16,
  parameter int CNT_W   = 8,
  parameter int MIN_LEN = 4,
  parameter int QW      = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_strap,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_q,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_q,
  input  logic          rd_eop,
  input  logic          rd_ov,
  input  logic [NQ-1:0] ae_in,
  output logic          pkt_mode,
  output logic [NQ-1:0] q_flag,
  output logic [NQ-1:0] pkt_err,
  output logic          rd_pkt_valid
);
  localparam int LW = $clog2(MIN_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [LW-1:0] LEN_TOP = LW'(MIN_LEN - 1);

  logic             mode_q;
  logic [CNT_W-1:0] cnt [NQ];
  logic [LW-1:0]    len [NQ];
  logic [NQ-1:0]    open_q, err_q, rdy, wsel, inc, dec, bad;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      wsel[i] = mode_q && wr_en && (wr_q == QW'(i));
      rdy[i]  = (cnt[i] != '0);
      dec[i]  = mode_q && rd_en && rd_eop && (rd_q == QW'(i)) && rdy[i];
      inc[i]  = wsel[i] && wr_eop && ((cnt[i] != CNT_MAX) || dec[i]);
      bad[i]  = wsel[i] && (wr_sop ? (open_q[i] || wr_eop)
                                   : (wr_eop && (!open_q[i] || len[i] < LEN_TOP)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= mode_strap;
      open_q <= '0;
      err_q  <= '0;
      for (int i = 0; i < NQ; i++) begin
        cnt[i] <= '0;
        len[i] <= '0;
      end
    end else begin
      err_q <= err_q | bad;
      for (int i = 0; i < NQ; i++) begin
        if (inc[i] && !dec[i])      cnt[i] <= cnt[i] + 1'b1;
        else if (dec[i] && !inc[i]) cnt[i] <= cnt[i] - 1'b1;
        if (wsel[i]) begin
          if (wr_sop) begin
            open_q[i] <= !wr_eop;
            len[i]    <= LW'(1);
          end else if (open_q[i]) begin
            if (wr_eop) begin
              open_q[i] <= 1'b0;
              len[i]    <= '0;
            end else if (len[i] != LEN_TOP) begin
              len[i] <= len[i] + 1'b1;
            end
          end
        end
      end
    end
  end

  assign pkt_mode     = mode_q;
  assign pkt_err      = err_q;
  assign q_flag       = mode_q ? rdy : ae_in;
  assign rd_pkt_valid = mode_q && rd_ov && rdy[rd_q];
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
module pkt_ready_tracker_chk #(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [QW-1:0] wr_q,
  input logic          wr_sop,
  input logic          wr_eop,
  input logic          rd_ov,
  input logic [NQ-1:0] ae_in,
  input logic          pkt_mode,
  input logic [NQ-1:0] q_flag,
  input logic [NQ-1:0] pkt_err,
  input logic          rd_pkt_valid
);
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(pkt_mode));

  p_word_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_mode |-> (q_flag == ae_in && pkt_err == '0));

  p_ready_after_eop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && wr_en && wr_eop) |=> q_flag[$past(wr_q)]);

  p_single_word_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_mode && wr_en && wr_sop && wr_eop) |=> pkt_err[$past(wr_q)]);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pkt_err & $past(pkt_err)) == $past(pkt_err)));

  p_avail_needs_ov_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pkt_valid |-> (rd_ov && pkt_mode));
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk #(.NQ(NQ), .QW(QW)) u_chk (.*);

// File: tb/pkt_ready_tracker_tb_top.sv
`timescale 1ns/1ps
module pkt_ready_tracker_tb_top;
  localparam int NQ = 16;
  localparam int QW = 4;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n, mode_strap, wr_en, wr_sop, wr_eop, rd_en, rd_eop, rd_ov;
  logic [QW-1:0] wr_q, rd_q;
  logic [NQ-1:0] ae_in, q_flag, pkt_err;
  logic pkt_mode, rd_pkt_valid;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  pkt_ready_tracker #(.NQ(NQ), .CNT_W(CNT_W), .MIN_LEN(4)) dut_i (.*);

  typedef struct packed {
    logic we; logic [3:0] wq; logic ws; logic wend;
    logic re; logic [3:0] rq; logic reop;
    logic [15:0] xflag; logic [15:0] xerr;
  } row_t;

  localparam int NROW = 9;
  localparam row_t TBL [NROW] = '{
    '{1'b1, 4'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 16'h0000},
    '{1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 16'h0000},
    '{1'b1, 4'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0000, 16'h0000},
    '{1'b1, 4'd2, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 16'h0004, 16'h0000},
    '{1'b1, 4'd5, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 16'h0004, 16'h0000},
    '{1'b1, 4'd5, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 16'h0024, 16'h0020},
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 16'h0020, 16'h0020},
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 16'h0020, 16'h0020},
    '{1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 16'h0000, 16'h0020}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [3:0] wq, input logic ws, input logic wend,
                     input logic re, input logic [3:0] rq, input logic reop);
    wr_en = we; wr_q = wq; wr_sop = ws; wr_eop = wend;
    rd_en = re; rd_q = rq; rd_eop = reop;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; rd_eop = 1'b0;
  endtask

  task automatic wpkt(input logic [3:0] q);
    cyc(1, q, 1, 0, 0, 0, 0);
    cyc(1, q, 0, 0, 0, 0, 0);
    cyc(1, q, 0, 0, 0, 0, 0);
    cyc(1, q, 0, 1, 0, 0, 0);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; mode_strap = strap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wr_en = 0; wr_q = 0; wr_sop = 0; wr_eop = 0;
    rd_en = 0; rd_q = 0; rd_eop = 0; rd_ov = 0; ae_in = 16'h0F0F;
    @(negedge clk);
    do_reset(1'b1);
    mode_strap = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 mode latched high", 32'(pkt_mode), 32'd1);
    check("R3 reset ready clear", 32'(q_flag), 32'h0);
    check("R9 reset err clear", 32'(pkt_err), 32'h0);

    for (int k = 0; k < NROW; k++) begin
      cyc(TBL[k].we, TBL[k].wq, TBL[k].ws, TBL[k].wend, TBL[k].re, TBL[k].rq, TBL[k].reop);
      check($sformatf("R3/R4/R7/R11 row %0d flags", k), 32'(q_flag), 32'(TBL[k].xflag));
      check($sformatf("R7/R11 row %0d errs", k), 32'(pkt_err), 32'(TBL[k].xerr));
    end

    // R5: queue 7 holds one packet, then a write end and a read end on the same edge
    wpkt(4'd7);
    cyc(1, 7, 1, 0, 0, 0, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    cyc(1, 7, 0, 1, 1, 7, 1);
    check("R5 same-edge count kept", 32'(q_flag[7]), 32'd1);
    cyc(0, 0, 0, 0, 1, 7, 1);
    check("R5 one read clears", 32'(q_flag[7]), 32'd0);

    // R6: nine packets against a ceiling of seven
    for (int k = 0; k < 9; k++) wpkt(4'd9);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1, 9, 1);
    check("R6 ready after six reads", 32'(q_flag[9]), 32'd1);
    cyc(0, 0, 0, 0, 1, 9, 1);
    check("R6 cleared after seven reads", 32'(q_flag[9]), 32'd0);
    check("R11 errs unchanged", 32'(pkt_err), 32'h0020);

    // R8: start inside open packet on 11, stray end on 12
    cyc(1, 11, 1, 0, 0, 0, 0);
    cyc(1, 11, 0, 0, 0, 0, 0);
    cyc(1, 11, 1, 0, 0, 0, 0);
    check("R8 nested start", 32'(pkt_err), 32'h0820);
    cyc(1, 12, 0, 1, 0, 0, 0);
    check("R8 stray end", 32'(pkt_err), 32'h1820);

    // R7: single word with both markers on queue 14
    cyc(1, 14, 1, 1, 0, 0, 0);
    check("R7 one-word packet", 32'(pkt_err), 32'h5820);

    // R10
    wpkt(4'd3);
    rd_q = 3; rd_ov = 1; #1;
    check("R10 ready and valid", 32'(rd_pkt_valid), 32'd1);
    rd_ov = 0; #1;
    check("R10 no output valid", 32'(rd_pkt_valid), 32'd0);
    rd_q = 4; rd_ov = 1; #1;
    check("R10 other queue empty", 32'(rd_pkt_valid), 32'd0);
    rd_ov = 0;

    // R1/R2/R9: word mode after reset
    @(negedge clk);
    do_reset(1'b0);
    mode_strap = 1'b1;
    ae_in = 16'hA5C3;
    @(posedge clk); @(negedge clk);
    check("R1 mode latched low", 32'(pkt_mode), 32'd0);
    check("R9 reset clears errs", 32'(pkt_err), 32'h0);
    check("R2 flags pass through", 32'(q_flag), 32'hA5C3);
    cyc(1, 6, 1, 1, 0, 0, 0);
    cyc(1, 6, 0, 1, 1, 6, 1);
    check("R2 no errs in word mode", 32'(pkt_err), 32'h0);
    ae_in = 16'h1234; #1;
    check("R2 flags follow ae_in", 32'(q_flag), 32'h1234);
    rd_q = 6; rd_ov = 1; #1;
    check("R10 low in word mode", 32'(rd_pkt_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule